// File: doc/BRIEF.md
# PCI Target Backend Decoder with Burst Register File

This block sits on the user side of a PCI target core. When the core raises its start-of-transaction strobe, the shared 32-bit bus carries the target address and the 4-bit bus carries the PCI command. In that cycle the block decodes the command into user-read and user-write intents. It also checks the address against a memory window and an I/O window. Each window is enabled by its own access-enable bit of the configuration command register. If the transaction is claimed, the block captures the address as a burst pointer and raises a read or write level for the rest of the transaction.

After the start cycle the shared bus carries write data, and the 4-bit bus carries active-low byte enables. Each transfer-complete pulse moves the pointer on by one DWORD (4 bytes). In a write, that pulse is also the write strobe for the current DWORD. The data is taken into a 16-entry register file at once, with no ready handshake, and only the enabled byte lanes change. In a read, the pulse means the core has placed the current word on the bus. The register file entry selected by the pointer is returned continuously while the read level is high.

Top module: `pcib_backend`

## Requirements
- R1: While `addr_strobe` is high, `user_rd_cmd` is 1 exactly for commands 4'b0010 (I/O read), 4'b0110 (memory read), 4'b1100 (memory read multiple) and 4'b1110 (memory read line). While `addr_strobe` is low it is 0.
- R2: While `addr_strobe` is high, `user_wr_cmd` is 1 exactly for commands 4'b0011 (I/O write) and 4'b0111 (memory write). While `addr_strobe` is low it is 0.
- R3: `hit_sel` rises for a memory command when `cmd_reg_en[1]` is 1 and the address matches `mem_bar` on all bits above the 256-byte window (bits 31:8). It is never 1 while `addr_strobe` is low.
- R4: `hit_sel` rises for an I/O command (4'b0010 or 4'b0011) when `cmd_reg_en[0]` is 1 and the address matches `io_bar` on bits 31:4 (a 16-byte window). An I/O address under a memory command, or a memory address under an I/O command, does not select.
- R5: On a strobe cycle, from the next edge `burst_ptr` holds the bus address. `wr_active` becomes the registered value of user-write AND select, and `rd_active` becomes user-read AND select. A transfer pulse in a strobe cycle writes nothing.
- R6: When a level is active and `addr_strobe` is low, each `xfer_pulse` adds 4 to `burst_ptr`. With no pulse, or with no active level, the pointer holds.
- R7: `dword_wr` equals `wr_active` AND `xfer_pulse` AND NOT `addr_strobe`. Every such pulse writes the bus data into entry `burst_ptr[5:2]`; no ready input exists to hold it off.
- R8: On a write pulse, byte lane i (bits 8i+7:8i) is updated only when `cbe_bus[i]` is 0. Other lanes keep their old value.
- R9: `rd_word` shows entry `burst_ptr[5:2]` while `rd_active` is 1, and shows zero otherwise.
- R10: `txn_end` clears both levels at the next edge. A pulse in the same cycle still completes its transfer: the data is written and the pointer advances.
- R11: The entry index wraps from 15 to 0 when the pointer crosses a 64-byte boundary in a burst.
- R12: After reset, `burst_ptr` is 0, both levels are 0, and every register file entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_strobe | input | 1 | Start of transaction: address and command valid |
| xfer_pulse | input | 1 | One data transfer has completed |
| txn_end | input | 1 | Current transaction is over |
| ad_bus | input | 32 | Address in the strobe cycle, write data afterwards |
| cbe_bus | input | 4 | Command in the strobe cycle, active-low byte enables afterwards |
| cmd_reg_en | input | 2 | Command register enables: bit 1 memory, bit 0 I/O |
| mem_bar | input | 32 | Memory window base |
| io_bar | input | 32 | I/O window base |
| user_rd_cmd | output | 1 | Strobe-qualified user-read decode |
| user_wr_cmd | output | 1 | Strobe-qualified user-write decode |
| hit_sel | output | 1 | Address claimed by one of the windows |
| rd_active | output | 1 | Read transaction in progress |
| wr_active | output | 1 | Write transaction in progress |
| dword_wr | output | 1 | Per-DWORD write strobe |
| burst_ptr | output | 32 | Current burst address |
| rd_word | output | 32 | Read data for the current DWORD |

## Verification
Two pairs of functions can act in the same cycle. In the first, the last write beat of a burst arrives together with the end of the transaction. The bench raises both in one cycle, expects the strobe to fire and the pointer to advance, expects the level to drop at the edge, and then reads the word back. In the second, a transfer pulse coincides with a new address strobe in the middle of a write burst. Here the bench expects no write strobe and expects the pointer to take the new address, and it confirms by read-back that the old entry was left unchanged.

// File: rtl/pcib_pkg.sv
package pcib_pkg;

    localparam int unsigned ADDR_W = 32;

    typedef logic [3:0] pci_cmd_t;

    localparam pci_cmd_t CMD_IO_RD    = 4'b0010;
    localparam pci_cmd_t CMD_IO_WR    = 4'b0011;
    localparam pci_cmd_t CMD_MEM_RD   = 4'b0110;
    localparam pci_cmd_t CMD_MEM_WR   = 4'b0111;
    localparam pci_cmd_t CMD_MEM_RDM  = 4'b1100;
    localparam pci_cmd_t CMD_MEM_RDL  = 4'b1110;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              rd;
        logic              wr;
    } burst_state_t;

    function automatic logic cmd_is_read(pci_cmd_t c);
        return (c == CMD_IO_RD) || (c == CMD_MEM_RD) ||
               (c == CMD_MEM_RDM) || (c == CMD_MEM_RDL);
    endfunction

    function automatic logic cmd_is_write(pci_cmd_t c);
        return (c == CMD_IO_WR) || (c == CMD_MEM_WR);
    endfunction

    function automatic logic cmd_is_io(pci_cmd_t c);
        return (c == CMD_IO_RD) || (c == CMD_IO_WR);
    endfunction

    function automatic logic cmd_is_mem(pci_cmd_t c);
        return (c == CMD_MEM_RD) || (c == CMD_MEM_WR) ||
               (c == CMD_MEM_RDM) || (c == CMD_MEM_RDL);
    endfunction

endpackage

// File: rtl/pcib_cmd_decode.sv
module pcib_cmd_decode
    import pcib_pkg::*;
(
    input  logic     strobe,
    input  pci_cmd_t cmd,
    output logic     rd_cmd,
    output logic     wr_cmd,
    output logic     mem_kind,
    output logic     io_kind
);

    always_comb begin
        rd_cmd   = strobe & cmd_is_read(cmd);
        wr_cmd   = strobe & cmd_is_write(cmd);
        mem_kind = strobe & cmd_is_mem(cmd);
        io_kind  = strobe & cmd_is_io(cmd);
    end

endmodule

// File: rtl/pcib_bar_match.sv
module pcib_bar_match
    import pcib_pkg::*;
#(
    parameter int unsigned SIZE = 256
)
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic              enable,
    input  logic              kind_ok,
    output logic              hit
);

    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(SIZE);
    localparam logic [ADDR_W-1:0] MASK = ~(SPAN - 1'b1);

    always_comb begin
        hit = enable & kind_ok & ((addr & MASK) == (base & MASK));
    end

endmodule

// File: rtl/pcib_regfile.sv
module pcib_regfile #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 32
)
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] widx,
    input  logic [DW/8-1:0]          be_n,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] ridx,
    output logic [DW-1:0]            rdata
);

    localparam int unsigned LANES = DW / 8;

    logic [DW-1:0]    mem_d [DEPTH];
    logic [DW-1:0]    mem_q [DEPTH];
    logic [LANES-1:0] lane_we;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_we[l] = we & ~be_n[l];
    end

    always_comb begin
        for (int e = 0; e < DEPTH; e++) begin
            mem_d[e] = mem_q[e];
        end
        for (int l = 0; l < LANES; l++) begin
            if (lane_we[l]) begin
                mem_d[widx][l*8 +: 8] = wdata[l*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                mem_q[e] <= '0;
            end
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                mem_q[e] <= mem_d[e];
            end
        end
    end

    assign rdata = mem_q[ridx];

endmodule

// File: rtl/pcib_backend.sv
module pcib_backend
    import pcib_pkg::*;
#(
    parameter int unsigned MEM_SIZE = 256,
    parameter int unsigned IO_SIZE  = 16,
    parameter int unsigned RF_DEPTH = 16
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_strobe,
    input  logic              xfer_pulse,
    input  logic              txn_end,
    input  logic [ADDR_W-1:0] ad_bus,
    input  logic [3:0]        cbe_bus,
    input  logic [1:0]        cmd_reg_en,
    input  logic [ADDR_W-1:0] mem_bar,
    input  logic [ADDR_W-1:0] io_bar,
    output logic              user_rd_cmd,
    output logic              user_wr_cmd,
    output logic              hit_sel,
    output logic              rd_active,
    output logic              wr_active,
    output logic              dword_wr,
    output logic [ADDR_W-1:0] burst_ptr,
    output logic [31:0]       rd_word
);

    localparam int unsigned IDX_W = $clog2(RF_DEPTH);
    localparam logic [ADDR_W-1:0] DWORD_STEP = ADDR_W'(4);

    logic mem_kind, io_kind;
    logic mem_hit, io_hit;
    logic [31:0] rf_rdata;
    logic [IDX_W-1:0] rf_idx;

    burst_state_t st_d, st_q;

    pcib_cmd_decode u_dec (
        .strobe   (addr_strobe),
        .cmd      (cbe_bus),
        .rd_cmd   (user_rd_cmd),
        .wr_cmd   (user_wr_cmd),
        .mem_kind (mem_kind),
        .io_kind  (io_kind)
    );

    pcib_bar_match #(.SIZE(MEM_SIZE)) u_mem_bar (
        .addr    (ad_bus),
        .base    (mem_bar),
        .enable  (cmd_reg_en[1]),
        .kind_ok (mem_kind),
        .hit     (mem_hit)
    );

    pcib_bar_match #(.SIZE(IO_SIZE)) u_io_bar (
        .addr    (ad_bus),
        .base    (io_bar),
        .enable  (cmd_reg_en[0]),
        .kind_ok (io_kind),
        .hit     (io_hit)
    );

    assign hit_sel = mem_hit | io_hit;

    always_comb begin
        st_d     = st_q;
        dword_wr = st_q.wr & xfer_pulse & ~addr_strobe;
        if (addr_strobe) begin
            st_d.ptr = ad_bus;
            st_d.rd  = user_rd_cmd & hit_sel;
            st_d.wr  = user_wr_cmd & hit_sel;
        end else begin
            if (xfer_pulse && (st_q.rd || st_q.wr)) begin
                st_d.ptr = st_q.ptr + DWORD_STEP;
            end
            if (txn_end) begin
                st_d.rd = 1'b0;
                st_d.wr = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rf_idx = st_q.ptr[IDX_W+1:2];

    pcib_regfile #(.DEPTH(RF_DEPTH), .DW(32)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dword_wr),
        .widx  (rf_idx),
        .be_n  (cbe_bus),
        .wdata (ad_bus),
        .ridx  (rf_idx),
        .rdata (rf_rdata)
    );

    assign burst_ptr = st_q.ptr;
    assign rd_active = st_q.rd;
    assign wr_active = st_q.wr;
    assign rd_word   = st_q.rd ? rf_rdata : 32'd0;

endmodule

// File: rtl/pcib_checker.sv
module pcib_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        addr_strobe,
    input logic        xfer_pulse,
    input logic        txn_end,
    input logic [31:0] ad_bus,
    input logic        user_rd_cmd,
    input logic        user_wr_cmd,
    input logic        hit_sel,
    input logic        rd_active,
    input logic        wr_active,
    input logic        dword_wr,
    input logic [31:0] burst_ptr
);

    a_r1_r2_decode_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(user_rd_cmd && user_wr_cmd));

    a_r3_idle_no_decode: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_strobe |-> (!user_rd_cmd && !user_wr_cmd && !hit_sel));

    a_r5_capture_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |=> burst_ptr == $past(ad_bus));

    a_r5_capture_write_level: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |=> wr_active == $past(user_wr_cmd && hit_sel));

    a_r5_capture_read_level: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |=> rd_active == $past(user_rd_cmd && hit_sel));

    a_r6_step_by_four: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_pulse && !addr_strobe && (rd_active || wr_active))
            |=> burst_ptr == $past(burst_ptr) + 32'd4);

    a_r6_hold_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_strobe && !xfer_pulse) |=> $stable(burst_ptr));

    a_r7_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
        dword_wr |-> (wr_active && xfer_pulse && !addr_strobe));

    a_r7_levels_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_active && wr_active));

    a_r10_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_end && !addr_strobe) |=> (!rd_active && !wr_active));

endmodule

bind pcib_backend pcib_checker u_pcib_checker (.*);

// File: tb/test_pcib_backend.sv
`timescale 1ns/1ps
module test_pcib_backend;

    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_strobe = 1'b0;
    logic        xfer_pulse = 1'b0;
    logic        txn_end = 1'b0;
    logic [31:0] ad_bus = '0;
    logic [3:0]  cbe_bus = '0;
    logic [1:0]  cmd_reg_en = 2'b11;
    logic [31:0] mem_bar = 32'h4000_0100;
    logic [31:0] io_bar  = 32'h0000_1230;
    logic        user_rd_cmd, user_wr_cmd, hit_sel;
    logic        rd_active, wr_active, dword_wr;
    logic [31:0] burst_ptr, rd_word;

    int total = 0;
    int bad = 0;
    logic [31:0] model [16];
    logic [31:0] exp_ptr = '0;

    always #(CLK_NS/2) clk = ~clk;

    pcib_backend i_pcib_backend (
        .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe),
        .xfer_pulse(xfer_pulse), .txn_end(txn_end), .ad_bus(ad_bus),
        .cbe_bus(cbe_bus), .cmd_reg_en(cmd_reg_en), .mem_bar(mem_bar),
        .io_bar(io_bar), .user_rd_cmd(user_rd_cmd), .user_wr_cmd(user_wr_cmd),
        .hit_sel(hit_sel), .rd_active(rd_active), .wr_active(wr_active),
        .dword_wr(dword_wr), .burst_ptr(burst_ptr), .rd_word(rd_word)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_txn();
        txn_end = 1'b1;
        tick();
        txn_end = 1'b0;
    endtask

    task automatic start_txn(input logic [31:0] a, input logic [3:0] c);
        addr_strobe = 1'b1; ad_bus = a; cbe_bus = c;
        tick();
        addr_strobe = 1'b0;
        exp_ptr = a;
        check("R5 pointer capture", burst_ptr, a);
    endtask

    task automatic wr_beat(input logic [31:0] d, input logic [3:0] be_n, input logic last);
        logic [3:0] idx;
        ad_bus = d; cbe_bus = be_n; xfer_pulse = 1'b1; txn_end = last;
        #1;
        check("R7 write strobe", 32'(dword_wr), 32'd1);
        idx = exp_ptr[5:2];
        for (int l = 0; l < 4; l++) begin
            if (!be_n[l]) model[idx][l*8 +: 8] = d[l*8 +: 8];
        end
        tick();
        xfer_pulse = 1'b0; txn_end = 1'b0;
        exp_ptr = exp_ptr + 32'd4;
        check("R6 pointer step on write", burst_ptr, exp_ptr);
    endtask

    task automatic rd_beat(input logic last);
        #1;
        check("R9 read data", rd_word, model[exp_ptr[5:2]]);
        xfer_pulse = 1'b1; txn_end = last;
        tick();
        xfer_pulse = 1'b0; txn_end = 1'b0;
        exp_ptr = exp_ptr + 32'd4;
        check("R6 pointer step on read", burst_ptr, exp_ptr);
    endtask

    task automatic t_reset();
        check("R12 pointer reset", burst_ptr, 32'd0);
        check("R12 read level reset", 32'(rd_active), 32'd0);
        check("R12 write level reset", 32'(wr_active), 32'd0);
        check("R9 idle read data zero", rd_word, 32'd0);
        start_txn(mem_bar, 4'b0110);
        for (int i = 0; i < 16; i++) begin
            check("R12 register file cleared", rd_word, 32'd0);
            xfer_pulse = 1'b1; tick(); xfer_pulse = 1'b0;
        end
        finish_txn();
    endtask

    task automatic t_decode();
        for (int c = 0; c < 16; c++) begin
            logic er, ew, es;
            er = (c == 2) || (c == 6) || (c == 12) || (c == 14);
            ew = (c == 3) || (c == 7);
            es = (c == 6) || (c == 7) || (c == 12) || (c == 14);
            addr_strobe = 1'b1; ad_bus = mem_bar + 32'h10; cbe_bus = 4'(c);
            #1;
            check("R1 read decode", 32'(user_rd_cmd), 32'(er));
            check("R2 write decode", 32'(user_wr_cmd), 32'(ew));
            check("R3 memory select by command", 32'(hit_sel), 32'(es));
            tick();
        end
        addr_strobe = 1'b0; cbe_bus = 4'b0110;
        #1;
        check("R1 read decode gated", 32'(user_rd_cmd), 32'd0);
        cbe_bus = 4'b0111;
        #1;
        check("R2 write decode gated", 32'(user_wr_cmd), 32'd0);
        check("R3 select gated", 32'(hit_sel), 32'd0);
        finish_txn();
    endtask

    task automatic probe_sel(input string tag, input logic [31:0] a, input logic [3:0] c,
                             input logic [1:0] en, input logic exp);
        cmd_reg_en = en; addr_strobe = 1'b1; ad_bus = a; cbe_bus = c;
        #1;
        check(tag, 32'(hit_sel), 32'(exp));
        tick();
        addr_strobe = 1'b0;
        cmd_reg_en = 2'b11;
    endtask

    task automatic t_bar();
        probe_sel("R3 memory top of window", mem_bar + 32'hFC, 4'b0110, 2'b11, 1'b1);
        probe_sel("R3 memory above window", mem_bar + 32'h100, 4'b0110, 2'b11, 1'b0);
        probe_sel("R3 memory below window", mem_bar - 32'h4, 4'b0111, 2'b11, 1'b0);
        probe_sel("R3 memory enable off", mem_bar, 4'b0110, 2'b01, 1'b0);
        probe_sel("R4 io hit", io_bar + 32'hC, 4'b0010, 2'b11, 1'b1);
        probe_sel("R4 io above window", io_bar + 32'h10, 4'b0011, 2'b11, 1'b0);
        probe_sel("R4 io enable off", io_bar, 4'b0011, 2'b10, 1'b0);
        probe_sel("R4 io address with memory command", io_bar, 4'b0110, 2'b11, 1'b0);
        probe_sel("R4 memory address with io command", mem_bar, 4'b0010, 2'b11, 1'b0);
        finish_txn();
    endtask

    task automatic t_write_read_burst();
        start_txn(mem_bar + 32'h08, 4'b0111);
        check("R5 write level", 32'(wr_active), 32'd1);
        wr_beat(32'h1111_1111, 4'b0000, 1'b0);
        wr_beat(32'h2222_2222, 4'b0000, 1'b0);
        wr_beat(32'h3333_3333, 4'b0000, 1'b0);
        #1;
        check("R6 pointer holds without pulse", burst_ptr, exp_ptr);
        tick();
        check("R6 pointer holds without pulse", burst_ptr, exp_ptr);
        finish_txn();
        check("R10 write level cleared", 32'(wr_active), 32'd0);
        start_txn(mem_bar + 32'h08, 4'b1110);
        check("R5 read level", 32'(rd_active), 32'd1);
        rd_beat(1'b0);
        rd_beat(1'b0);
        rd_beat(1'b1);
        check("R10 read level cleared", 32'(rd_active), 32'd0);
        check("R9 read data zero after end", rd_word, 32'd0);
    endtask

    task automatic t_byte_lanes();
        start_txn(mem_bar + 32'h08, 4'b0111);
        wr_beat(32'hAABB_CCDD, 4'b1010, 1'b1);
        start_txn(mem_bar + 32'h08, 4'b1100);
        #1;
        check("R8 byte lanes 0 and 2 only", rd_word, 32'h11BB_11DD);
        rd_beat(1'b1);
    endtask

    task automatic t_wrap();
        start_txn(mem_bar + 32'h3C, 4'b0111);
        wr_beat(32'hF00D_000F, 4'b0000, 1'b0);
        wr_beat(32'hBEEF_0000, 4'b0000, 1'b1);
        check("R11 pointer crosses boundary", burst_ptr, mem_bar + 32'h44);
        start_txn(mem_bar + 32'h3C, 4'b0110);
        rd_beat(1'b0);
        #1;
        check("R11 entry 0 after wrap", rd_word, 32'hBEEF_0000);
        rd_beat(1'b1);
    endtask

    task automatic t_overlaps();
        start_txn(mem_bar + 32'h20, 4'b0111);
        wr_beat(32'hCAFE_0001, 4'b0000, 1'b0);
        wr_beat(32'hCAFE_0002, 4'b0000, 1'b1);
        check("R10 level dropped with last beat", 32'(wr_active), 32'd0);
        xfer_pulse = 1'b1; ad_bus = 32'h5555_5555;
        #1;
        check("R7 no strobe after end", 32'(dword_wr), 32'd0);
        tick();
        xfer_pulse = 1'b0;
        check("R6 pointer holds with no level", burst_ptr, exp_ptr);
        start_txn(mem_bar + 32'h30, 4'b0111);
        wr_beat(32'h7777_0001, 4'b0000, 1'b0);
        addr_strobe = 1'b1; xfer_pulse = 1'b1; ad_bus = mem_bar + 32'h00; cbe_bus = 4'b0110;
        #1;
        check("R5 no strobe on address cycle", 32'(dword_wr), 32'd0);
        tick();
        addr_strobe = 1'b0; xfer_pulse = 1'b0;
        exp_ptr = mem_bar;
        check("R5 new address wins over pulse", burst_ptr, mem_bar);
        finish_txn();
        start_txn(mem_bar + 32'h34, 4'b0110);
        #1;
        check("R5 entry untouched by address cycle", rd_word, model[13]);
        rd_beat(1'b1);
        start_txn(mem_bar + 32'h20, 4'b0110);
        rd_beat(1'b0);
        rd_beat(1'b1);
    endtask

    task automatic t_unclaimed();
        start_txn(mem_bar + 32'h100, 4'b0111);
        check("R5 unclaimed write no level", 32'(wr_active), 32'd0);
        xfer_pulse = 1'b1; ad_bus = 32'hDEAD_DEAD; cbe_bus = 4'b0000;
        #1;
        check("R7 unclaimed no strobe", 32'(dword_wr), 32'd0);
        tick();
        xfer_pulse = 1'b0;
        start_txn(mem_bar + 32'h00, 4'b0110);
        #1;
        check("R7 unclaimed write left entry 0", rd_word, model[0]);
        rd_beat(1'b1);
    endtask

    initial begin
        #(CLK_NS * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int e = 0; e < 16; e++) model[e] = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_bar();
        t_write_read_burst();
        t_byte_lanes();
        t_wrap();
        t_overlaps();
        t_unclaimed();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule